// File: doc/BRIEF.md
# Multi-Bank Interrupt Control Unit

This block collects interrupt requests from several banks of 32 lines each and presents them to a processor. Each bank latches incoming requests into a status register, gates the latched requests with an enable register, and exposes the gated result as an output-status view. For each bank the block drives one interrupt output toward the processor. It also gives the number of the highest active line in that bank, which is the line software should service next.

Software reaches the registers over a simple 32-bit register bus. All banks have the same register set, placed at a fixed byte stride. Software clears latched requests by writing ones to the status register. A request-set register lets software force status bits for test. A per-line mode bit chooses between edge capture and level capture. When a new request arrives in the same cycle that software clears it, the new request wins, so no event is lost.

Top module: `icu_multibank`

## Requirements
- R1: After reset, every status, enable and mode bit is 0, every `irq_out` bit is 0 and every `top_valid` bit is 0.
- R2: Bank b occupies byte addresses b*0x28 to b*0x28+0x27. Within a bank the offsets are: status 0x00, enable 0x08, output status 0x10, request-set 0x18 and mode 0x20. A read returns its data on `bus_rdata` with `bus_rvalid` high one cycle after `bus_rd`. Reads of the request-set register, of any other offset, or of any address past the last bank return 0.
- R3: With its mode bit at 0, a line that goes from 0 to 1 sets its status bit at the next clock edge. The bit stays set after the line falls.
- R4: Writing the status register clears every status bit whose data bit is 1. Data bits of 0 leave the status bit unchanged.
- R5: If a set event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R6: Writing a 1 to a bit of the request-set register sets that status bit. Data bits of 0 have no effect.
- R7: The output-status register reads as status AND enable. Writes to it have no effect.
- R8: `top_idx` for bank b (bits b*5+4:b*5) is the highest bit number set in that bank's output status. `top_valid[b]` is 1 exactly when that output status is nonzero.
- R9: `irq_out[b]` equals the OR of bank b's output status as it was one clock cycle earlier.
- R10: With its mode bit at 1, a line held high sets its status bit at every clock edge. A clear write therefore does not stick while the line stays high.
- R11: A write to one bank leaves every other bank's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_BANKS*32 | Request lines; bank b uses bits b*32+31:b*32 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_out | output | NUM_BANKS | Registered interrupt output per bank |
| top_idx | output | NUM_BANKS*5 | Highest active line number per bank |
| top_valid | output | NUM_BANKS | Bank has at least one active line |

## Verification
The following are checked by assertions on every cycle:
- a set event always leaves its status bit set, and a clear removes only bits with no competing set;
- `top_idx` always names the top set bit of the output status;
- `irq_out` always tracks the previous cycle's OR of the output status;
- at most one bank decodes any address, and read data follows each read strobe.

The following can only be shown by the bench's scenarios:
- the address map and the bank stride;
- the fact that zero bits in clear and set writes have no effect;
- writes to output status being ignored;
- level-mode relatching while a line stays high;
- the isolation between banks.

// File: rtl/icu_pkg.sv
package icu_pkg;

   localparam int unsigned LINES_PER_BANK = 32;
   localparam int unsigned IDX_W          = $clog2(LINES_PER_BANK);

   localparam int unsigned OFS_STATUS  = 'h00;
   localparam int unsigned OFS_ENABLE  = 'h08;
   localparam int unsigned OFS_OUTSTAT = 'h10;
   localparam int unsigned OFS_SET     = 'h18;
   localparam int unsigned OFS_MODE    = 'h20;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_ENABLE,
      SEL_OUTSTAT,
      SEL_SET,
      SEL_MODE
   } icu_sel_e;

   function automatic icu_sel_e decode_offset(input int unsigned ofs);
      case (ofs)
         OFS_STATUS:  decode_offset = SEL_STATUS;
         OFS_ENABLE:  decode_offset = SEL_ENABLE;
         OFS_OUTSTAT: decode_offset = SEL_OUTSTAT;
         OFS_SET:     decode_offset = SEL_SET;
         OFS_MODE:    decode_offset = SEL_MODE;
         default:     decode_offset = SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/icu_addr_dec.sv
module icu_addr_dec
   import icu_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 6,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STRIDE    = 'h28
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] bank_hit,
   output icu_sel_e             reg_sel
);

   localparam int unsigned OFS_W = $clog2(STRIDE);

   logic [OFS_W-1:0] ofs;

   always_comb begin
      bank_hit = '0;
      ofs      = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (int'(addr) >= b * STRIDE && int'(addr) < (b + 1) * STRIDE) begin
            bank_hit[b] = 1'b1;
            ofs         = OFS_W'(int'(addr) - b * STRIDE);
         end
      end
      reg_sel = (|bank_hit) ? decode_offset(int'(ofs)) : SEL_NONE;
   end

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_hit)); // R2

endmodule

// File: rtl/icu_msb_find.sv
module icu_msb_find #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IW   = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] vec,
   output logic [IW-1:0]    idx,
   output logic             valid
);

   always_comb begin
      idx   = '0;
      valid = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
         if (vec[i]) begin
            idx   = IW'(i);
            valid = 1'b1;
         end
      end
   end

   AST_IDX_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((vec >> idx) == WIDTH'(1))); // R8
   AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (vec == '0)); // R8

endmodule

// File: rtl/icu_bank.sv
module icu_bank
   import icu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lines,
   input  logic             hit,
   input  icu_sel_e         reg_sel,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] status,
   output logic [WIDTH-1:0] enable,
   output logic [WIDTH-1:0] mode,
   output logic [WIDTH-1:0] outstat
);

   logic [WIDTH-1:0] lines_q;
   logic [WIDTH-1:0] rise_v;
   logic [WIDTH-1:0] src_v;
   logic [WIDTH-1:0] set_mask;
   logic [WIDTH-1:0] clr_mask;
   logic             wr_here;

   assign wr_here  = hit && wr;
   assign rise_v   = lines & ~lines_q;
   assign src_v    = rise_v | (mode & lines);
   assign set_mask = (wr_here && reg_sel == SEL_SET)    ? wdata : '0;
   assign clr_mask = (wr_here && reg_sel == SEL_STATUS) ? wdata : '0;
   assign outstat  = status & enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lines_q <= '0;
         status  <= '0;
         enable  <= '0;
         mode    <= '0;
      end else begin
         lines_q <= lines;
         status  <= (status & ~clr_mask) | src_v | set_mask;
         if (wr_here && reg_sel == SEL_ENABLE) enable <= wdata;
         if (wr_here && reg_sel == SEL_MODE)   mode   <= wdata;
      end
   end

   AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_v) |=> ((status & $past(src_v)) == $past(src_v))); // R5
   AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_mask) |=> ((status & $past(set_mask)) == $past(set_mask))); // R6
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_mask) |=> ((status & $past(clr_mask & ~src_v & ~set_mask)) == '0)); // R4

endmodule

// File: rtl/icu_multibank.sv
module icu_multibank
   import icu_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 6,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STRIDE    = 'h28,
   localparam int unsigned LW       = LINES_PER_BANK,
   localparam int unsigned IW       = IDX_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_BANKS*LW-1:0] irq_lines,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [LW-1:0]           bus_wdata,
   output logic [LW-1:0]           bus_rdata,
   output logic                    bus_rvalid,
   output logic [NUM_BANKS-1:0]    irq_out,
   output logic [NUM_BANKS*IW-1:0] top_idx,
   output logic [NUM_BANKS-1:0]    top_valid
);

   if (NUM_BANKS < 1 || NUM_BANKS > 6) begin : g_bad_banks
      initial $fatal(1, "NUM_BANKS must be 1..6");
   end
   if (NUM_BANKS * STRIDE > (1 << ADDR_W)) begin : g_bad_addr
      initial $fatal(1, "ADDR_W too narrow for bank map");
   end
   if (STRIDE <= OFS_MODE) begin : g_bad_stride
      initial $fatal(1, "STRIDE too small for register set");
   end

   logic [NUM_BANKS-1:0] bank_hit;
   icu_sel_e             reg_sel;
   logic [LW-1:0]        st_v  [NUM_BANKS];
   logic [LW-1:0]        en_v  [NUM_BANKS];
   logic [LW-1:0]        md_v  [NUM_BANKS];
   logic [LW-1:0]        os_v  [NUM_BANKS];
   logic [LW-1:0]        rd_mux;

   icu_addr_dec #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .STRIDE    (STRIDE)
   ) i_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .bank_hit (bank_hit),
      .reg_sel  (reg_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      icu_bank #(.WIDTH(LW)) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .lines   (irq_lines[b*LW +: LW]),
         .hit     (bank_hit[b]),
         .reg_sel (reg_sel),
         .wr      (bus_wr),
         .wdata   (bus_wdata),
         .status  (st_v[b]),
         .enable  (en_v[b]),
         .mode    (md_v[b]),
         .outstat (os_v[b])
      );

      icu_msb_find #(.WIDTH(LW)) i_find (
         .clk   (clk),
         .rst_n (rst_n),
         .vec   (os_v[b]),
         .idx   (top_idx[b*IW +: IW]),
         .valid (top_valid[b])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b]) begin
            case (reg_sel)
               SEL_STATUS:  rd_mux = st_v[b];
               SEL_ENABLE:  rd_mux = en_v[b];
               SEL_OUTSTAT: rd_mux = os_v[b];
               SEL_MODE:    rd_mux = md_v[b];
               default:     rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
         irq_out    <= '0;
      end else begin
         bus_rvalid <= bus_rd;
         bus_rdata  <= bus_rd ? rd_mux : '0;
         irq_out    <= top_valid;
      end
   end

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_out == $past(top_valid))); // R9
   AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid); // R2

endmodule

// File: tb/test_icu_multibank.sv
module test_icu_multibank;
   localparam int NB = 6;
   localparam int AW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NB*32-1:0] irq_lines = '0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            bus_rvalid;
   logic [NB-1:0]   irq_out;
   logic [NB*5-1:0] top_idx;
   logic [NB-1:0]   top_valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   icu_multibank #(.NUM_BANKS(NB), .ADDR_W(AW)) i_icu_multibank (
      .clk, .rst_n, .irq_lines, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
      .bus_rdata, .bus_rvalid, .irq_out, .top_idx, .top_valid
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = AW'(a);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // Monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(32'(irq_out), 0, "R1 irq_out");
      chk(32'(top_valid), 0, "R1 top_valid");
      rd('h08, 0, "R1 enable");
      rd('h00, 0, "R1 status");
      rd('h20, 0, "R1 mode");

      // R3: edge on bank0 line 3
      @(negedge clk); irq_lines[3] = 1'b1;
      @(negedge clk); irq_lines[3] = 1'b0;
      rd('h00, 32'h8, "R3 edge latched");
      rd('h10, 32'h0, "R7 outstat gated");
      chk(32'(irq_out[0]), 0, "R9 no irq while disabled");

      wr('h08, 32'hFFFF_FFFF);
      chk(32'(top_valid[0]), 1, "R8 valid");
      chk(32'(top_idx[4:0]), 3, "R8 idx 3");
      chk(32'(irq_out[0]), 0, "R9 irq one cycle late");
      @(negedge clk);
      chk(32'(irq_out[0]), 1, "R9 irq raised");
      rd('h10, 32'h8, "R7 outstat");
      rd('h08, 32'hFFFF_FFFF, "R2 enable readback");

      @(negedge clk); irq_lines[20] = 1'b1;
      @(negedge clk);
      chk(32'(top_idx[4:0]), 20, "R8 highest wins");
      rd('h00, 32'h0010_0008, "R3 two bits");

      wr('h00, 32'h0);
      rd('h00, 32'h0010_0008, "R4 zero write");
      wr('h00, 32'h8);
      rd('h00, 32'h0010_0000, "R4 one clears");
      wr('h10, 32'h0);
      rd('h10, 32'h0010_0000, "R7 outstat write ignored");

      // R5: edge and clear together
      @(negedge clk); irq_lines[20] = 1'b0;
      @(negedge clk);
      irq_lines[20] = 1'b1;
      bus_wr = 1'b1; bus_addr = 'h00; bus_wdata = 32'h0010_0000;
      @(negedge clk); bus_wr = 1'b0;
      rd('h00, 32'h0010_0000, "R5 set beats clear");

      wr('h00, 32'hFFFF_FFFF);
      rd('h00, 32'h0, "R4 clear all");
      chk(32'(top_valid[0]), 0, "R8 empty");
      chk(32'(irq_out[0]), 0, "R9 irq dropped");

      // R6 and R11: bank 2 via stride
      wr('h68, 32'h8000_0001);
      rd('h50, 32'h8000_0001, "R6 forced set");
      rd('h00, 32'h0, "R11 bank0 untouched");
      wr('h68, 32'h0);
      rd('h50, 32'h8000_0001, "R6 zero no effect");
      wr('h58, 32'h8000_0000);
      @(negedge clk);
      chk(32'(irq_out), 32'b000100, "R11 only bank2 irq");
      chk(32'(top_idx[14:10]), 31, "R8 bank2 idx 31");

      // R10: level mode in bank 1 line 5
      wr('h48, 32'h20);
      rd('h48, 32'h20, "R2 mode readback");
      @(negedge clk); irq_lines[37] = 1'b1;
      @(negedge clk);
      wr('h28, 32'h20);
      rd('h28, 32'h20, "R10 relatch while high");
      @(negedge clk); irq_lines[37] = 1'b0;
      wr('h28, 32'h20);
      rd('h28, 32'h0, "R10 clear after low");

      // R2: map edges
      rd('h04, 32'h0, "R2 hole offset");
      rd('hF0, 32'h0, "R2 past last bank");
      rd('h68, 32'h0, "R2 set reg reads zero");
      wr('hD0, 32'h5A5A_5A5A);
      rd('hD0, 32'h5A5A_5A5A, "R2 last bank enable");

      repeat (3) @(negedge clk);
      chk(32'(exp_q.size()), 0, "R2 all reads answered");
      finish_run();
   end
endmodule